// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps a two-bank SDRAM refreshed on behalf of a memory controller. A free-running interval timer adds one owed refresh to a small counter every refresh period. While refreshes are owed, the block raises a request to the main command scheduler. Once the scheduler grants the bus, which it does only when both banks are precharged, the block drives an auto-refresh command and then holds no-operation commands for the recovery time. The scheduler may withhold the grant for a while. Owed refreshes then build up to a cap and are issued one after another once the grant returns.

A level low-power request starts a self-refresh cycle. The block first runs a full burst of auto-refreshes and then drives the self-refresh entry encoding with the clock enable low. It keeps the clock enable low for as long as the request stays high. When the request falls, it raises the clock enable with deselect commands for the row-cycle time. It then runs a second full burst and reports completion with a one-cycle pulse. The request output stays high from the first request through the end of the sequence, so the scheduler keeps off the command bus for that whole span.

Top module: `sdram_refresh_seq`

## Requirements
- R1: An auto-refresh is driven as cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. It appears only when ref_gnt was high and cke was high in the previous cycle.
- R2: One refresh becomes owed every INTERVAL = CLK_MHZ*WINDOW_US/REFRESHES cycles. With the grant held high in normal operation, consecutive auto-refreshes are exactly INTERVAL cycles apart.
- R3: While the grant is withheld, owed refreshes accumulate up to MAX_PEND, and further ones are dropped. When the grant returns, every accumulated refresh is issued without waiting for a new interval.
- R4: With REC = max(TRC_CYC, TRP_CYC), each auto-refresh is followed by REC-1 cycles of NOP (cs_n=0, ras_n=cas_n=we_n=1). No auto-refresh or self-refresh entry comes earlier than REC cycles after the previous auto-refresh.
- R5: ref_req is high whenever the block drives cs_n low. It is low when the block is idle with nothing owed.
- R6: A high lp_req seen while idle starts a burst of BURST_LEN auto-refreshes. If lp_req is still high at the end of the burst, the block drives the self-refresh entry encoding (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0).
- R7: In self-refresh, cke stays low, in_self_refresh is high, cs_n stays high, and no refresh is issued, however long lp_req stays high.
- R8: When lp_req falls in self-refresh, cke rises with cs_n=1 for TRC_CYC cycles. BURST_LEN auto-refreshes follow, the first one cycle after that wait when the grant is high. sr_exit_done then pulses for exactly one cycle.
- R9: If lp_req falls during the pre-entry burst, the burst still completes, no self-refresh entry is made, and cke never falls.
- R10: During reset the outputs are deselect with cke=1, and ref_req, in_self_refresh and sr_exit_done are low.
- R11: The start of each burst clears the owed count and restarts the interval. The first periodic refresh after a post-exit burst therefore comes INTERVAL+1 cycles after that burst's first refresh, whatever the length of the self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req | input | 1 | Level request for self-refresh |
| ref_gnt | input | 1 | Scheduler grant; both banks are precharged |
| ref_req | output | 1 | Request for the command bus |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable |
| in_self_refresh | output | 1 | Device is held in self-refresh |
| sr_exit_done | output | 1 | One-cycle pulse when the exit burst completes |

## Verification
The assertions assume that the scheduler raises ref_gnt only when both banks are idle. They also assume it leaves the command bus alone while ref_req is high. The assertions check only what the sequencer itself drives. The bench raises or lowers the grant and lp_req just after a clock edge. It starts every outage or low-power request a known number of cycles after an observed periodic refresh, so that the owed count and the interval phase are known when each check is made.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int WINDOW_US = 32000,
  parameter int REFRESHES = 2048,
  parameter int TRC_CYC   = 7,
  parameter int TRP_CYC   = 3,
  parameter int BURST_LEN = 4096,
  parameter int MAX_PEND  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic cmd_cs_n,
  output logic cmd_ras_n,
  output logic cmd_cas_n,
  output logic cmd_we_n,
  output logic cmd_cke,
  output logic in_self_refresh,
  output logic sr_exit_done
);
  localparam int INTERVAL = CLK_MHZ * WINDOW_US / REFRESHES;
  localparam int REC_CYC  = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
  localparam int TW = $clog2(INTERVAL);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int BW = $clog2(BURST_LEN + 1);
  localparam int CW = $clog2(REC_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_AR, S_REC, S_SRE, S_SR, S_SRX} st_t;
  typedef enum logic [1:0] {B_NONE, B_PRE, B_POST} bm_t;

  st_t           st;
  bm_t           bm;
  logic [TW-1:0] timer;
  logic [PW-1:0] pend;
  logic [PW:0]   pend_nx;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic          cke_q, done_q;

  wire tick     = (timer == TW'(INTERVAL - 1));
  wire burst_go = (st == S_IDLE && lp_req) || (st == S_SRX && cnt == '0);
  wire ar_fire  = (st == S_AR);
  wire dec      = ar_fire && bm == B_NONE;
  wire rec_end  = (st == S_REC) && cnt == '0;

  assign pend_nx = {1'b0, pend} + (PW+1)'(tick) - (PW+1)'(dec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
      pend  <= '0;
    end else begin
      timer <= (burst_go || tick) ? '0 : timer + TW'(1);
      if (burst_go)
        pend <= '0;
      else if (pend_nx > (PW+1)'(MAX_PEND))
        pend <= PW'(MAX_PEND);
      else
        pend <= pend_nx[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bm     <= B_NONE;
      cnt    <= '0;
      left   <= '0;
      cke_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      cke_q  <= cmd_cke;
      done_q <= rec_end && bm == B_POST && left == '0;
      if (ar_fire && bm != B_NONE) left <= left - BW'(1);
      case (st)
        S_IDLE: begin
          if (lp_req) begin
            st   <= S_REQ;
            bm   <= B_PRE;
            left <= BW'(BURST_LEN);
          end else if (pend != '0) begin
            st <= S_REQ;
          end
        end
        S_REQ: if (ref_gnt && cke_q) st <= S_AR;
        S_AR: begin
          st  <= S_REC;
          cnt <= CW'(REC_CYC - 2);
        end
        S_REC: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (bm != B_NONE && left != '0) begin
            st <= S_REQ;
          end else if (bm == B_PRE && lp_req) begin
            st <= S_SRE;
            bm <= B_NONE;
          end else begin
            st <= S_IDLE;
            bm <= B_NONE;
          end
        end
        S_SRE: st <= S_SR;
        S_SR: begin
          if (!lp_req) begin
            st  <= S_SRX;
            cnt <= CW'(TRC_CYC - 1);
          end
        end
        S_SRX: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else begin
            st   <= S_REQ;
            bm   <= B_POST;
            left <= BW'(BURST_LEN);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ref_req         = (st != S_IDLE);
  assign cmd_cke         = !(st == S_SRE || st == S_SR);
  assign cmd_cs_n        = !(st == S_AR || st == S_SRE || st == S_REC);
  assign cmd_ras_n       = !(st == S_AR || st == S_SRE);
  assign cmd_cas_n       = !(st == S_AR || st == S_SRE);
  assign cmd_we_n        = 1'b1;
  assign in_self_refresh = (st == S_SR);
  assign sr_exit_done    = done_q;

  assert_ar_gnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cs_n && !cmd_ras_n && cmd_cke) |-> ($past(ref_gnt) && $past(cmd_cke)));

  assert_pend_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= MAX_PEND);

  assert_rec_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cs_n && !cmd_ras_n && cmd_cke) |=> (!cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n));

  assert_cmd_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cs_n |-> ref_req);

  assert_sr_cke_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_self_refresh |-> (!cmd_cke && cmd_cs_n && ref_req));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_done |=> !sr_exit_done);
endmodule

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_refresh_seq_tb;
  localparam int IV    = 40;
  localparam int TRC   = 5;
  localparam int TRP   = 3;
  localparam int REC   = 5;
  localparam int BURST = 3;
  localparam int MAXP  = 4;

  logic clk = 0, rst_n = 0, lp_req = 0, ref_gnt = 1;
  logic ref_req, cs_n, ras_n, cas_n, we_n, cke, in_sr, done;

  always #4 clk = ~clk;

  sdram_refresh_seq #(.CLK_MHZ(1), .WINDOW_US(320), .REFRESHES(8), .TRC_CYC(TRC),
    .TRP_CYC(TRP), .BURST_LEN(BURST), .MAX_PEND(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_cke(cke), .in_self_refresh(in_sr), .sr_exit_done(done));

  int tests = 0, fails = 0;
  int ncyc = 0, ar_total = 0, sre_total = 0, low_cyc = 0, done_total = 0;
  int last_ar = 0, cke_rise = 0, nop_left = 0, srx_left = 0;
  bit seen_ar = 0, prev_gnt = 0, prev_cke = 1, finished = 0;
  event ar_ev, sre_ev, done_ev;

  wire is_ar  = !cs_n && !ras_n && !cas_n && we_n && cke;
  wire is_sre = !cs_n && !ras_n && !cas_n && we_n && !cke;
  wire is_nop = !cs_n && ras_n && cas_n && we_n;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    ncyc++;
    if (!cs_n && !ref_req) check(0, "R5 bus owned", 0, 1);
    if (!prev_cke && cke) begin cke_rise = ncyc; srx_left = TRC; end
    if (srx_left > 0) begin
      check(cs_n && cke, "R8 exit deselect", cs_n, 1);
      srx_left--;
    end
    if (is_ar || is_sre) begin
      if (is_ar) check(prev_gnt && prev_cke, "R1 grant and cke", prev_gnt, 1);
      if (seen_ar) check(ncyc - last_ar >= REC, "R4 spacing", ncyc - last_ar, REC);
      if (is_ar) begin
        ar_total++; last_ar = ncyc; seen_ar = 1; nop_left = REC - 1;
        -> ar_ev;
      end else begin
        sre_total++; -> sre_ev;
      end
    end else if (nop_left > 0) begin
      check(is_nop, "R4 nop", is_nop, 1);
      nop_left--;
    end
    if (!cke) low_cyc++;
    if (done) begin done_total++; -> done_ev; end
    prev_gnt = ref_gnt;
    prev_cke = cke;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t, snap, a1, n0, l0, s0;
    repeat (3) @(posedge clk);
    #1;
    check(cs_n && cke && !ref_req && !in_sr && !done, "R10 reset", {cs_n, cke, ref_req, in_sr, done}, 5'b11000);
    rst_n = 1;

    // R2: steady spacing
    @(ar_ev);
    for (int i = 0; i < 4; i++) begin
      t = last_ar;
      @(ar_ev);
      check(last_ar - t == IV, "R2 interval", last_ar - t, IV);
    end

    // R3: outage sweep
    for (int k = 1; k <= 6; k++) begin
      int exp;
      exp = (k < MAXP) ? k : MAXP;
      @(ar_ev);
      @(posedge clk); #1 ref_gnt = 0;
      repeat (k * IV) @(posedge clk);
      #1 ref_gnt = 1;
      snap = ar_total;
      repeat (32) @(posedge clk);
      #1 check(ar_total - snap == exp, "R3 postponed", ar_total - snap, exp);
    end

    // R6, R7: entry
    @(ar_ev);
    repeat (10) @(posedge clk);
    #1 snap = ar_total; s0 = sre_total; lp_req = 1;
    @(sre_ev);
    check(ar_total - snap == BURST, "R6 pre burst", ar_total - snap, BURST);
    check(sre_total == s0 + 1, "R6 entry", sre_total - s0, 1);
    l0 = low_cyc; n0 = ncyc; snap = ar_total;
    repeat (200) @(posedge clk);
    #1;
    check(low_cyc - l0 == ncyc - n0, "R7 cke low", low_cyc - l0, ncyc - n0);
    check(in_sr && ref_req && cs_n, "R7 status", in_sr, 1);
    check(ar_total == snap, "R7 no refresh", ar_total - snap, 0);

    // R8, R11: exit
    lp_req = 0;
    @(ar_ev);
    a1 = last_ar;
    check(a1 - cke_rise == TRC + 1, "R8 exit wait", a1 - cke_rise, TRC + 1);
    @(done_ev);
    check(ar_total - snap == BURST, "R8 post burst", ar_total - snap, BURST);
    @(negedge clk);
    check(!done, "R8 pulse width", done, 0);
    check(!ref_req, "R5 release", ref_req, 0);
    @(ar_ev);
    check(last_ar - a1 == IV + 1, "R11 restart", last_ar - a1, IV + 1);

    // R9: abandoned entry
    repeat (10) @(posedge clk);
    #1 snap = ar_total; s0 = sre_total; l0 = low_cyc; lp_req = 1;
    @(ar_ev);
    @(posedge clk); #1 lp_req = 0;
    repeat (35) @(posedge clk);
    #1;
    check(ar_total - snap == BURST, "R9 burst", ar_total - snap, BURST);
    check(sre_total == s0 && low_cyc == l0, "R9 no entry", sre_total - s0, 0);
    check(!ref_req && cke, "R9 idle", ref_req, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule